// File: doc/BRIEF.md
# PWM Time-Base Counter Unit

This block is the shared time base of a multi-channel PWM generator. A 16-bit counter advances once for every prescaler tick. It can count up to the period and restart at zero, count down from the period and restart there, or in center-aligned operation run up to the period and back down to zero. Each turn-around of the counter is an overflow or underflow. It produces an update event, and that event is where the prescaler and period shadow copies move into their active registers.

A host programs the block through one write port. It selects the prescaler, the period or the control byte, and it has a separate strobe that forces an update by software. The control byte holds these settings:

- run enable
- one-pulse mode
- edge direction
- a 2-bit alignment field
- period preload
- update disable
- update-request source

The outputs are the counter value, the counting direction, a one-cycle update pulse and a sticky update flag. The host clears the flag with a pulse on a separate input.

Internally a three-state machine drives the counter. Its states are CS_STOP (halted, value held), CS_UP and CS_DOWN. The transitions are:

- CS_STOP→CS_UP when run is set in center mode or edge-up mode.
- CS_STOP→CS_DOWN when run is set in edge-down mode.
- CS_UP→CS_DOWN at the peak in center mode.
- CS_DOWN→CS_UP at zero in center mode.
- From CS_UP or CS_DOWN to CS_STOP when run clears.
- In edge mode, at a wrap the machine enters the state matching the direction bit.
- A software strobe puts the machine in the state for the current mode, or in CS_STOP while halted.

Top module: `pwm_timebase`

## Requirements
- R1: After reset, cnt_val is 0, cnt_down is 0, update_evt is 0 and update_flag is 0.
- R2: Edge-up (control bits [4:3]=00, bit 2=0). The counter steps 0..period once per prescaler tick. At the tick after it reaches the period it returns to 0 and an update event occurs. Events are (psc+1)*(period+1) clocks apart, and cnt_val is 0 in the cycle update_evt is high.
- R3: Edge-down (bits [4:3]=00, bit 2=1). The counter steps from the period down to 0 and then reloads the period with an update event. Events are (psc+1)*(period+1) clocks apart, and cnt_val equals the period while update_evt is high.
- R4: Alignment codes 01, 10 and 11 in bits [4:3] select center mode. The counter rises to the period and then falls to 0. An event occurs at both turns, so events are (psc+1)*period clocks apart. At the peak event cnt_val=period-1 with cnt_down=1, and at the valley event cnt_val=1 with cnt_down=0.
- R5: Writes with wr_sel=0 go to the prescaler shadow. The active prescaler changes only at an update event, and then each count lasts psc+1 clocks.
- R6: Writes with wr_sel=1 set the period. With the preload bit (control bit 5) at 0, the new period applies at once.
- R7: With preload bit 5 at 1, a period write goes only to the shadow. The active period takes the shadow value at the next update event.
- R8: With one-pulse bit 1 set, an overflow or underflow update event clears run bit 0. The counter then holds its value and produces no further events.
- R9: With source bit 7 at 0, counter wraps and the software strobe both set update_flag. With bit 7 at 1, only counter wraps set it, though the strobe still pulses update_evt.
- R10: With update-disable bit 6 set, the block produces no update events and reloads no shadow registers, while the counter keeps wrapping.
- R11: A software strobe (sw_update high) restarts the prescaler and loads every shadow into its active register. It sets the counter to 0 in up or center mode, or to the period shadow value in edge-down mode.
- R12: A control write (wr_sel=2) made while run is 1 leaves the alignment field unchanged. The other bits are still written.
- R13: update_flag stays 1 until a flag_clr pulse. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 prescaler, 1 period, 2 control |
| wr_data | input | DW (16) | Write data (control uses bits 7:0) |
| sw_update | input | 1 | Software update strobe |
| flag_clr | input | 1 | Clears update_flag |
| cnt_val | output | CNT_W (16) | Counter value |
| cnt_down | output | 1 | 1 while counting downwards |
| update_evt | output | 1 | One-cycle update event pulse |
| update_flag | output | 1 | Sticky update request flag |

## Verification
A vector table sweeps edge-up, edge-down and two center codes, each at unit and non-unit prescale. The spacing between events separates the (period+1) edge formula from the period-only center formula. The counter value sampled at each event separates the three restart points.

Directed runs cover the following cases:
- Mid-period writes with preload off, preload on and update disabled. The largest value the counter reaches shows whether the active period changed.
- Prescaler writes, to show that they wait for an event.
- The strobe under each source setting, to show which events set the flag.
- One-pulse runs, to show that the counter stops.
- A locked alignment write, which must leave the edge timing unchanged.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

    typedef enum logic [1:0] {
        CS_STOP = 2'd0,
        CS_UP   = 2'd1,
        CS_DOWN = 2'd2
    } cnt_state_e;

    typedef enum logic [1:0] {
        WS_PSC = 2'd0,
        WS_PER = 2'd1,
        WS_CTL = 2'd2
    } wsel_e;

    // control byte, MSB first
    typedef struct packed {
        logic       src_ovf_only;  // 7
        logic       upd_off;       // 6
        logic       per_preload;   // 5
        logic [1:0] align;         // 4:3
        logic       dir_down;      // 2
        logic       one_shot;      // 1
        logic       run;           // 0
    } ctl_t;

endpackage

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt;

    assign tick = run && !restart && (pcnt >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (restart)
            pcnt <= '0;
        else if (run) begin
            if (pcnt >= div)
                pcnt <= '0;
            else
                pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             center,
    input  logic             dir_down,
    input  logic             load_ok,
    input  logic             reinit,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output cnt_state_e       state,
    output logic             wrap
);
    cnt_state_e       st_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] eff;
    logic             edge_dn;

    assign eff     = load_ok ? reload : limit;
    assign edge_dn = !center && dir_down;

    always_comb begin
        st_nx  = state;
        cnt_nx = cnt;
        wrap   = 1'b0;
        if (reinit) begin
            cnt_nx = edge_dn ? reload : '0;
            st_nx  = !run ? CS_STOP : (edge_dn ? CS_DOWN : CS_UP);
        end else begin
            unique case (state)
                CS_STOP: begin
                    if (run) st_nx = edge_dn ? CS_DOWN : CS_UP;
                end
                CS_UP: begin
                    if (!run) st_nx = CS_STOP;
                    else if (tick) begin
                        if (cnt >= limit) begin
                            wrap = 1'b1;
                            if (center) begin
                                st_nx  = CS_DOWN;
                                cnt_nx = (eff == '0) ? '0 : eff - 1'b1;
                            end else begin
                                cnt_nx = dir_down ? eff : '0;
                                st_nx  = dir_down ? CS_DOWN : CS_UP;
                            end
                        end else
                            cnt_nx = cnt + 1'b1;
                    end
                end
                CS_DOWN: begin
                    if (!run) st_nx = CS_STOP;
                    else if (tick) begin
                        if (cnt == '0) begin
                            wrap = 1'b1;
                            if (center) begin
                                st_nx  = CS_UP;
                                cnt_nx = (eff == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
                            end else begin
                                cnt_nx = dir_down ? eff : '0;
                                st_nx  = dir_down ? CS_DOWN : CS_UP;
                            end
                        end else
                            cnt_nx = cnt - 1'b1;
                    end
                end
                default: st_nx = CS_STOP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CS_STOP;
        else        state <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nx;
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import ptb_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter int               PSC_W      = 16,
    parameter int               DW         = 16,
    parameter logic [CNT_W-1:0] DEF_PERIOD = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic             sw_update,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_val,
    output logic             cnt_down,
    output logic             update_evt,
    output logic             update_flag
);
    localparam int CTL_W = $bits(ctl_t);

    ctl_t             ctl_q, ctl_nx;
    logic [PSC_W-1:0] psc_pre, psc_act;
    logic [CNT_W-1:0] arr_pre, arr_act;
    logic             tick, wrap, ovf_evt, sw_evt, uev, flag_set;
    logic             ctl_wr, psc_wr, per_wr;
    cnt_state_e       state;

    assign ctl_wr   = wr_en && (wr_sel == WS_CTL);
    assign psc_wr   = wr_en && (wr_sel == WS_PSC);
    assign per_wr   = wr_en && (wr_sel == WS_PER);
    assign ovf_evt  = wrap && !ctl_q.upd_off;
    assign sw_evt   = sw_update && !ctl_q.upd_off;
    assign uev      = ovf_evt || sw_evt;
    assign flag_set = ovf_evt || (sw_evt && !ctl_q.src_ovf_only);

    always_comb begin
        ctl_nx = ctl_q;
        if (ctl_wr) begin
            ctl_nx = ctl_t'(wr_data[CTL_W-1:0]);
            if (ctl_q.run) ctl_nx.align = ctl_q.align;
        end else if (ovf_evt && ctl_q.one_shot)
            ctl_nx.run = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            psc_pre     <= '0;
            psc_act     <= '0;
            arr_pre     <= DEF_PERIOD;
            arr_act     <= DEF_PERIOD;
            update_evt  <= 1'b0;
            update_flag <= 1'b0;
        end else begin
            ctl_q <= ctl_nx;
            if (psc_wr) psc_pre <= wr_data[PSC_W-1:0];
            if (uev)    psc_act <= psc_pre;
            if (per_wr) arr_pre <= wr_data[CNT_W-1:0];
            if (per_wr && !ctl_q.per_preload) arr_act <= wr_data[CNT_W-1:0];
            else if (uev)                     arr_act <= arr_pre;
            update_evt <= uev;
            if (flag_set)      update_flag <= 1'b1;
            else if (flag_clr) update_flag <= 1'b0;
        end
    end

    ptb_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(ctl_q.run), .restart(sw_evt),
        .div(psc_act), .tick(tick)
    );

    ptb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctl_q.run), .tick(tick),
        .center(ctl_q.align != 2'b00), .dir_down(ctl_q.dir_down),
        .load_ok(!ctl_q.upd_off), .reinit(sw_evt),
        .limit(arr_act), .reload(arr_pre),
        .cnt(cnt_val), .state(state), .wrap(wrap)
    );

    assign cnt_down = (state == CS_DOWN);
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             one_shot,
    input logic             upd_off,
    input logic             src_only,
    input logic             preload,
    input logic [1:0]       align,
    input logic [CNT_W-1:0] arr_act,
    input logic             uev,
    input logic             wrap,
    input logic             ctl_wr,
    input logic             flag_clr,
    input logic             update_evt,
    input logic             update_flag
);
    // R10
    a_r10_no_evt_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        upd_off |=> !update_evt);
    // R8
    a_r8_one_shot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (run && one_shot && wrap && !upd_off && !ctl_wr) |=> !run);
    // R9
    a_r9_src_ovf_only: assert property (@(posedge clk) disable iff (!rst_n)
        (src_only && !wrap && !update_flag) |=> !update_flag);
    // R13
    a_r13_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (update_flag && !flag_clr) |=> update_flag);
    // R7
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (preload && !uev) |=> $stable(arr_act));
    // R12
    a_r12_align_locked: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(align));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(ctl_q.run), .one_shot(ctl_q.one_shot),
    .upd_off(ctl_q.upd_off), .src_only(ctl_q.src_ovf_only),
    .preload(ctl_q.per_preload), .align(ctl_q.align), .arr_act(arr_act),
    .uev(uev), .wrap(wrap), .ctl_wr(ctl_wr), .flag_clr(flag_clr),
    .update_evt(update_evt), .update_flag(update_flag)
);

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;
    localparam int RUN = 1, ONE = 2, DN = 4, PRE = 32, UOFF = 64, SRC = 128;
    localparam int NV = 6;
    // align, dir, psc, period, expected event spacing
    localparam int VEC [NV][5] = '{
        '{0, 0, 0, 3, 4},
        '{0, 0, 2, 4, 15},
        '{0, 1, 0, 5, 6},
        '{0, 1, 1, 2, 6},
        '{1, 0, 0, 4, 4},
        '{3, 0, 1, 3, 6}
    };

    logic        clk = 0, rst_n = 0;
    logic        wr_en = 0, sw_update = 0, flag_clr = 0;
    logic [1:0]  wr_sel = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] cnt_val;
    logic        cnt_down, update_evt, update_flag;
    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwm_timebase u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sw_update(sw_update), .flag_clr(flag_clr), .cnt_val(cnt_val),
        .cnt_down(cnt_down), .update_evt(update_evt), .update_flag(update_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1; wr_sel = 2'(sel); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic strobe();
        @(negedge clk); sw_update = 1;
        @(negedge clk); sw_update = 0;
    endtask

    task automatic clr();
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
    endtask

    task automatic wait_evt(output int n, output int mx);
        n = 0; mx = 0;
        forever begin
            @(negedge clk);
            n++;
            if (int'(cnt_val) > mx) mx = int'(cnt_val);
            if (update_evt) break;
            if (n > 3000) begin
                check(0, "event timeout", n, 0);
                break;
            end
        end
    endtask

    task automatic setup(input int bits, input int psc, input int per);
        wr(2, 0); wr(0, psc); wr(1, per);
        wr(2, bits & ~RUN); strobe(); wr(2, bits);
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n, mx, ev, lo;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cnt_val == 0 && !cnt_down, "R1 cnt/dir", int'(cnt_val), 0);
        check(!update_evt && !update_flag, "R1 evt/flag", int'(update_flag), 0);
        rst_n = 1;

        // table: R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            setup(RUN | (VEC[i][0] << 3) | (VEC[i][1] ? DN : 0), VEC[i][2], VEC[i][3]);
            wait_evt(n, mx);
            wait_evt(n, mx);
            check(n == VEC[i][4], "R2/R3/R4 event spacing", n, VEC[i][4]);
            if (VEC[i][0] != 0)
                check(int'(cnt_val) == (cnt_down ? VEC[i][3] - 1 : 1), "R4 turn value",
                      int'(cnt_val), cnt_down ? VEC[i][3] - 1 : 1);
            else if (VEC[i][1] != 0)
                check(int'(cnt_val) == VEC[i][3], "R3 restart value", int'(cnt_val), VEC[i][3]);
            else
                check(cnt_val == 0, "R2 restart value", int'(cnt_val), 0);
        end

        // R6 immediate period
        setup(RUN, 0, 3);
        wait_evt(n, mx);
        wr(1, 9);
        wait_evt(n, mx);
        check(mx == 9, "R6 immediate max", mx, 9);
        wait_evt(n, mx);
        check(n == 10, "R6 new spacing", n, 10);

        // R7 preloaded period
        setup(RUN | PRE, 0, 3);
        wait_evt(n, mx);
        wr(1, 9);
        wait_evt(n, mx);
        check(mx == 3, "R7 shadow held", mx, 3);
        wait_evt(n, mx);
        check(n == 10 && mx == 9, "R7 loaded spacing", n, 10);

        // R5 prescaler shadowed
        setup(RUN, 0, 3);
        wait_evt(n, mx);
        wr(0, 3);
        wait_evt(n, mx);
        check(n <= 4, "R5 old prescale kept", n, 4);
        wait_evt(n, mx);
        check(n == 16, "R5 new prescale", n, 16);

        // R10 update disable
        setup(RUN | PRE, 0, 3);
        wait_evt(n, mx);
        wr(2, RUN | PRE | UOFF);
        wr(1, 9);
        clr();
        ev = 0; mx = 0; lo = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (update_evt) ev++;
            if (int'(cnt_val) > mx) mx = int'(cnt_val);
            if (cnt_val == 0) lo++;
        end
        check(ev == 0, "R10 no events", ev, 0);
        check(mx == 3 && lo > 0, "R10 no reload, still wraps", mx, 3);
        check(!update_flag, "R10 flag untouched", int'(update_flag), 0);

        // R8 one pulse
        setup(RUN | ONE, 0, 3);
        wait_evt(n, mx);
        ev = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (update_evt) ev++;
        end
        check(ev == 0, "R8 no further events", ev, 0);
        check(cnt_val == 0, "R8 counter held", int'(cnt_val), 0);

        // R9 flag source
        wr(2, 0);
        clr();
        strobe();
        check(update_evt && update_flag, "R9 strobe sets flag (src=0)", int'(update_flag), 1);
        wr(2, SRC);
        clr();
        strobe();
        check(update_evt == 1, "R9 strobe event (src=1)", int'(update_evt), 1);
        check(!update_flag, "R9 strobe no flag (src=1)", int'(update_flag), 0);
        wr(2, SRC | RUN);
        wait_evt(n, mx);
        check(update_flag == 1, "R9 overflow sets flag (src=1)", int'(update_flag), 1);

        // R13 sticky flag
        wr(2, SRC);
        repeat (8) @(negedge clk);
        check(update_flag == 1, "R13 flag held", int'(update_flag), 1);
        clr();
        check(!update_flag, "R13 flag cleared", int'(update_flag), 0);

        // R11 software reinit
        wr(2, 0); wr(1, 6); wr(2, DN);
        strobe();
        check(cnt_val == 6, "R11 down reinit", int'(cnt_val), 6);
        wr(2, 0);
        strobe();
        check(cnt_val == 0, "R11 up reinit", int'(cnt_val), 0);
        wr(2, PRE | DN); wr(1, 2);
        strobe();
        check(cnt_val == 2, "R11 shadow loaded", int'(cnt_val), 2);

        // R12 alignment locked while running
        setup(RUN, 0, 3);
        wait_evt(n, mx);
        wr(2, RUN | (1 << 3));
        wait_evt(n, mx);
        wait_evt(n, mx);
        check(n == 4, "R12 edge spacing kept", n, 4);
        check(cnt_val == 0 && !cnt_down, "R12 edge restart kept", int'(cnt_val), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule